// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Flush

This block paces fetch and execute for a small controller core that uses 16-bit instruction words. Each instruction cycle lasts four clock periods, and the block drives one phase strobe in each period. The fetch address is on the program-memory port for the whole cycle. On the last clock of the cycle the block commits: it loads the fetched word into the instruction register and advances the fetch address. The core's decoder watches the instruction register and returns hints for the instruction that is executing: whether it is two words long, whether it is a branch, whether a conditional skip is taken, and the branch target.

From these hints the block chooses what the next cycle holds. It can be a normal first-word cycle, the second word of a two-word instruction, or a forced NOP cycle. A forced NOP cycle follows a redirected program counter or a taken skip. A word whose top nibble is all ones is the marker of a second word, and if it arrives on its own it also executes as a NOP. The `execEn` and `nopInserted` levels let the core, or a bench, count the penalty cycles.

Top module: `instr_cycle_seq`

## Requirements
- R1: `phaseStb` is one-hot and steps from bit 0 to bit 3, one bit per clock, starting with bit 0 in the first clock after reset. An instruction cycle is the four clocks from bit 0 to bit 3, and all state and outputs other than `phaseStb` change only at the clock edge that ends bit 3.
- R2: During reset, and through the first cycle after it: `progAddr` and `pcOut` are 0, `instrReg` is the NOP word 0x0000, and `execEn` and `nopInserted` are both low. The word at address 0 is fetched in that first cycle.
- R3: A plain one-word instruction executes in one cycle. At each commit that loads a word, `instrReg` takes the word fetched at `progAddr`, `pcOut` takes that address, and `progAddr` advances by one unless a redirect applies.
- R4: When `isBranch` is high and `isTwoWord` is low at the end of a first-word cycle, the next cycle is a NOP cycle (`nopInserted` high, `instrReg` = 0x0000), and during it `progAddr` equals the sampled `branchTarget`.
- R5: When `skipTaken` is high at the end of a first-word cycle of a non-branch one-word instruction, the prefetched word is replaced by a NOP cycle, and `progAddr` moves on past that word.
- R6: A word whose bits [15:12] are 1111 that is committed anywhere other than the second slot of a two-word instruction gives a NOP cycle: `nopInserted` high, `execEn` low, `instrReg` = 0x0000.
- R7: When `isTwoWord` is high and `isBranch` is low at the end of a first-word cycle, the next cycle holds the second word with `execEn` high and `nopInserted` low, whatever that word's top nibble is.
- R8: A two-word instruction with `isBranch` high takes three cycles: the first word, the second word, and then a NOP cycle. `branchTarget` is sampled at the end of the second-word cycle and is the fetch address during the NOP cycle.
- R9: A branch takes priority over `skipTaken`. The hints are ignored at the end of NOP cycles and the start-up cycle. `isBranch`, `isTwoWord` and `skipTaken` are also ignored at the end of second-word cycles.
- R10: A taken skip whose prefetched word begins a two-word instruction produces two consecutive NOP cycles, one for each word of that instruction.
- R11: `execEn` and `nopInserted` are never high together. Both hold steady across all four clocks of a cycle. Each flush or orphan word gives exactly one cycle of `nopInserted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| progData | input | 16 | Word read from program memory at `progAddr` |
| isTwoWord | input | 1 | Hint: executing instruction occupies two words |
| isBranch | input | 1 | Hint: executing instruction redirects the program counter |
| skipTaken | input | 1 | Hint: executing conditional test succeeded |
| branchTarget | input | 12 | Redirect address, valid in a branch's last execute cycle |
| progAddr | output | 12 | Fetch address for program memory |
| phaseStb | output | 4 | One-hot phase strobes |
| pcOut | output | 12 | Address of the word held in `instrReg` |
| instrReg | output | 16 | Instruction register |
| execEn | output | 1 | Cycle executes a real instruction word |
| nopInserted | output | 1 | Cycle is a forced NOP (flush or orphan word) |

## Verification
The hints are sampled at the clock edge that ends phase 3. Their effect appears on `instrReg`, `pcOut`, `execEn` and `nopInserted` from the first clock of the next cycle, and a redirect shows on `progAddr` in that same clock. `phaseStb` moves one step on every clock. The bench keeps its own cycle-level model of the program and steps it only after every fourth clock edge since reset release. It compares all outputs at the falling edge of every clock, so each result is checked in the cycle it is due and in each of the three clocks where it must hold. Between first-word cycles, random noise is driven on the hints so that any use of them outside their sampling slot shows up as a mismatch.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;

  typedef enum logic [2:0] {
    KIND_START,
    KIND_FIRST,
    KIND_SECOND,
    KIND_FLUSH,
    KIND_ORPHAN
  } cycKind_e;

  typedef struct packed {
    logic commit;
    logic takeTarget;
    logic loadNop;
  } seqStrobe_t;

endpackage

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int PHASES = 4,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TAG_W-1:0]  progTag,
  input  logic              isTwoWord,
  input  logic              isBranch,
  input  logic              skipTaken,
  output logic [PHASES-1:0] phaseStb,
  output seqStrobe_t        strb,
  output logic              execEn,
  output logic              nopInserted
);

  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);
  localparam logic [TAG_W-1:0] MARK = {TAG_W{1'b1}};

  logic [PH_W-1:0] phase;
  logic            lastPhase;
  cycKind_e        kind, kindNext;
  logic            pend, pendNext;
  logic            takeTarget, loadNop;

  assign lastPhase = (phase == LAST_PH);
  assign phaseStb  = PHASES'(1) << phase;

  always_comb begin
    kindNext   = kind;
    pendNext   = pend;
    takeTarget = 1'b0;
    loadNop    = 1'b0;
    if (kind == KIND_FIRST && isBranch && !isTwoWord) begin
      takeTarget = 1'b1;
      loadNop    = 1'b1;
      kindNext   = KIND_FLUSH;
    end else if (kind == KIND_FIRST && isTwoWord) begin
      kindNext = KIND_SECOND;
      pendNext = isBranch;
    end else if (kind == KIND_FIRST && skipTaken) begin
      loadNop  = 1'b1;
      kindNext = KIND_FLUSH;
    end else if (kind == KIND_SECOND && pend) begin
      takeTarget = 1'b1;
      loadNop    = 1'b1;
      kindNext   = KIND_FLUSH;
      pendNext   = 1'b0;
    end else if (progTag == MARK) begin
      loadNop  = 1'b1;
      kindNext = KIND_ORPHAN;
    end else begin
      kindNext = KIND_FIRST;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
      kind  <= KIND_START;
      pend  <= 1'b0;
    end else begin
      phase <= lastPhase ? '0 : phase + 1'b1;
      if (lastPhase) begin
        kind <= kindNext;
        pend <= pendNext;
      end
    end
  end

  assign strb.commit     = lastPhase;
  assign strb.takeTarget = takeTarget;
  assign strb.loadNop    = loadNop;
  assign execEn      = (kind == KIND_FIRST) || (kind == KIND_SECOND);
  assign nopInserted = (kind == KIND_FLUSH) || (kind == KIND_ORPHAN);

  // R1: exactly one strobe, and the last phase wraps to the first
  p_phase_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(phaseStb) == 1);
  p_phase_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    phaseStb[PHASES-1] |=> phaseStb[0]);
  // R11: mutually exclusive, steady within a cycle
  p_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(execEn && nopInserted));
  p_steady_r11: assert property (@(posedge clk) disable iff (!rstN)
    !phaseStb[0] |-> ($stable(execEn) && $stable(nopInserted)));
  // R4: one-word branch is followed by a NOP cycle
  p_branch_nop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lastPhase && kind == KIND_FIRST && isBranch && !isTwoWord) |=> nopInserted);
  // R7: second word executes
  p_second_exec_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lastPhase && kind == KIND_FIRST && isTwoWord) |=> (execEn && !nopInserted));
  // R8: two-word branch ends in a NOP cycle
  p_two_branch_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lastPhase && kind == KIND_SECOND && pend) |=> nopInserted);
  // R6: lone marker word becomes a NOP
  p_orphan_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lastPhase && (kind == KIND_START || kind == KIND_FLUSH || kind == KIND_ORPHAN)
     && progTag == MARK) |=> nopInserted);
  // R9: hints have no effect after a NOP cycle
  p_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lastPhase && kind == KIND_FLUSH && progTag != MARK) |=> execEn);

endmodule

// File: rtl/seq_datapath.sv
`timescale 1ns/1ps
module seq_datapath
  import seq_pkg::*;
#(
  parameter int               WORD_W   = 16,
  parameter int               PC_W     = 12,
  parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [WORD_W-1:0] progData,
  input  logic [PC_W-1:0]   branchTarget,
  output logic [PC_W-1:0]   progAddr,
  output logic [PC_W-1:0]   pcOut,
  output logic [WORD_W-1:0] instrReg
);

  logic [PC_W-1:0] fetchPc;
  logic [PC_W-1:0] execPc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchPc  <= '0;
      execPc   <= '0;
      instrReg <= NOP_WORD;
    end else if (strb.commit) begin
      fetchPc  <= strb.takeTarget ? branchTarget : fetchPc + PC_W'(1);
      execPc   <= fetchPc;
      instrReg <= strb.loadNop ? NOP_WORD : progData;
    end
  end

  assign progAddr = fetchPc;
  assign pcOut    = execPc;

  // R3: sequential fetch steps by one word
  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !strb.takeTarget) |=> fetchPc == $past(fetchPc) + PC_W'(1));
  p_exec_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> execPc == $past(fetchPc));
  // R4: redirect lands on the sampled target
  p_redirect_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.takeTarget) |=> fetchPc == $past(branchTarget));
  // R5: a flushed word never reaches the instruction register
  p_flush_word_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.loadNop) |=> instrReg == NOP_WORD);
  // R1: nothing moves between commits
  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(fetchPc) && $stable(instrReg)));

endmodule

// File: rtl/instr_cycle_seq.sv
`timescale 1ns/1ps
module instr_cycle_seq
  import seq_pkg::*;
#(
  parameter int                WORD_W   = 16,
  parameter int                PC_W     = 12,
  parameter int                PHASES   = 4,
  parameter int                TAG_W    = 4,
  parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] progData,
  input  logic              isTwoWord,
  input  logic              isBranch,
  input  logic              skipTaken,
  input  logic [PC_W-1:0]   branchTarget,
  output logic [PC_W-1:0]   progAddr,
  output logic [PHASES-1:0] phaseStb,
  output logic [PC_W-1:0]   pcOut,
  output logic [WORD_W-1:0] instrReg,
  output logic              execEn,
  output logic              nopInserted
);

  seqStrobe_t strb;

  seq_ctrl #(.PHASES(PHASES), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .progTag(progData[WORD_W-1 -: TAG_W]),
    .isTwoWord(isTwoWord), .isBranch(isBranch), .skipTaken(skipTaken),
    .phaseStb(phaseStb), .strb(strb),
    .execEn(execEn), .nopInserted(nopInserted)
  );

  seq_datapath #(.WORD_W(WORD_W), .PC_W(PC_W), .NOP_WORD(NOP_WORD)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .progData(progData), .branchTarget(branchTarget),
    .progAddr(progAddr), .pcOut(pcOut), .instrReg(instrReg)
  );

endmodule

// File: tb/instr_cycle_seq_tb.sv
`timescale 1ns/1ps
module instr_cycle_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] progData;
  logic        isTwoWord, isBranch, skipTaken;
  logic [11:0] branchTarget;
  logic [11:0] progAddr, pcOut;
  logic [3:0]  phaseStb;
  logic [15:0] instrReg;
  logic        execEn, nopInserted;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  instr_cycle_seq u_dut (
    .clk(clk), .rstN(rstN), .progData(progData),
    .isTwoWord(isTwoWord), .isBranch(isBranch), .skipTaken(skipTaken),
    .branchTarget(branchTarget), .progAddr(progAddr), .phaseStb(phaseStb),
    .pcOut(pcOut), .instrReg(instrReg), .execEn(execEn), .nopInserted(nopInserted)
  );

  // program memory and a stand-in core decoder
  logic [15:0] mem [64];
  assign progData = mem[progAddr[5:0]];

  // bench encoding: E=two-word branch, B=two-word plain, D=branch (bit6 also skip),
  // C=skip (taken if bit0), F=second word; target in bits [5:0]
  function automatic logic [14:0] decode(input logic [15:0] w);
    logic tw, br, sk;
    tw = (w[15:12] == 4'hE) || (w[15:12] == 4'hB);
    br = (w[15:12] == 4'hE) || (w[15:12] == 4'hD);
    sk = ((w[15:12] == 4'hD) && w[6]) || ((w[15:12] == 4'hC) && w[0]);
    return {tw, br, sk, 6'd0, w[5:0]};
  endfunction

  logic [14:0] noise;
  always_comb begin
    logic [14:0] d;
    d = decode(instrReg);
    if (!execEn) d = noise;                          // R9: noise outside execute
    else if (instrReg[15:12] == 4'hF) d[14:12] = noise[14:12];
    {isTwoWord, isBranch, skipTaken, branchTarget} = d;
  end

  // reference model: 0 start, 1 first, 2 second, 3 flush, 4 orphan
  int          mKind;
  bit          mPend, mSkipTwo;
  logic [11:0] mPc, mIrAddr;
  logic [15:0] mIr;
  string       mTag;

  task automatic advance();
    logic [15:0] w;
    logic [14:0] d;
    w = mem[mPc[5:0]];
    d = decode(mIr);
    mIrAddr = mPc;
    if (mKind == 1 && d[13] && !d[14]) begin
      mPc = {6'd0, mIr[5:0]}; mIr = 16'h0; mKind = 3;
      mTag = d[12] ? "R9" : "R4"; mSkipTwo = 0;
    end else if (mKind == 1 && d[14]) begin
      mIr = w; mPc = mPc + 1; mKind = 2; mPend = d[13];
      mTag = d[13] ? "R8" : "R7";
    end else if (mKind == 1 && d[12]) begin
      mIr = 16'h0; mPc = mPc + 1; mKind = 3; mTag = "R5";
      mSkipTwo = (w[15:12] == 4'hE) || (w[15:12] == 4'hB);
    end else if (mKind == 2 && mPend) begin
      mPc = {6'd0, mIr[5:0]}; mIr = 16'h0; mKind = 3; mPend = 0; mTag = "R8";
    end else if (w[15:12] == 4'hF) begin
      mIr = 16'h0; mPc = mPc + 1; mKind = 4;
      mTag = mSkipTwo ? "R10" : "R6"; mSkipTwo = 0;
    end else begin
      mIr = w; mPc = mPc + 1; mKind = 1; mTag = "R3"; mSkipTwo = 0;
    end
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic randProg();
    int i = 22;
    while (i < 63) begin
      int k = (i >= 61) ? $urandom_range(0, 2) : $urandom_range(0, 4);
      case (k)
        0: mem[i] = {4'($urandom_range(0, 9)), 12'($urandom)};
        1: mem[i] = {4'hC, 11'($urandom), 1'($urandom)};
        2: mem[i] = {4'hD, 5'($urandom), 1'($urandom), 6'($urandom)};
        default: begin
          mem[i] = {(k == 3) ? 4'hB : 4'hE, 12'($urandom)};
          i++;
          mem[i] = {4'hF, 6'($urandom), 6'($urandom)};
        end
      endcase
      i++;
    end
    mem[63] = 16'hD000;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) mem[i] = 16'h3000 | 16'(i);
    mem[0] = 16'h1234; mem[1] = 16'hC001; mem[2] = 16'h2000;
    mem[3] = 16'hC001; mem[4] = 16'hB000; mem[5] = 16'hF0AA;  // R10 skip over two-word
    mem[6] = 16'hC000; mem[7] = 16'hB111; mem[8] = 16'hF055;  // R7
    mem[9] = 16'hE000; mem[10] = 16'hF00E;                   // R8 to 14
    mem[14] = 16'hD054;                                      // R9 branch+skip to 20
    mem[20] = 16'hF123;                                      // R6 lone marker
    mem[21] = 16'hD020;                                      // to 32
    randProg();
    noise = '0;
    mKind = 0; mPend = 0; mSkipTwo = 0; mPc = 0; mIrAddr = 0; mIr = 0; mTag = "R2";

    repeat (3) @(negedge clk);
    check("R2", {52'd0, progAddr}, 64'd0);
    check("R2", {52'd0, pcOut}, 64'd0);
    check("R2", {48'd0, instrReg}, 64'd0);
    check("R2", {62'd0, execEn, nopInserted}, 64'd0);
    check("R1", {60'd0, phaseStb}, 64'd1);
    rstN = 1'b1;

    for (int k = 0; k < 10000; k++) begin
      noise = 15'($urandom);
      #0.5;
      check("R1", {60'd0, phaseStb}, 64'(4'b0001 << (k % 4)));
      check("R11", {62'd0, execEn, nopInserted},
            {62'd0, (mKind == 1 || mKind == 2), (mKind == 3 || mKind == 4)});
      check(mTag, {24'd0, progAddr, pcOut, instrReg},
            {24'd0, mPc, mIrAddr, mIr});
      @(posedge clk);
      if ((k + 1) % 4 == 0) advance();
      @(negedge clk);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule